// File: doc/BRIEF.md
# Double-Data-Rate Nibble Bridge Between an 8-bit MAC and a 4-bit PHY

This block joins a byte-wide MAC port to a PHY port that carries half as many data lines in each direction. On transmit it accepts a byte together with an enable flag and an error flag. It drives a 4-bit data bus and a single control line, and both change on the rising and on the falling clock edge. On receive it takes the 4-bit double-data-rate bus and its control line and rebuilds a byte, a data-valid flag and an error flag for the MAC.

The two flags of each direction share one wire. The rising half carries enable (or data-valid). The falling half carries the exclusive-OR of that flag with the error flag. A two-bit speed input selects gigabit operation or one of the two slower rates. At gigabit rate a whole byte crosses in every clock cycle, split into two nibbles across the two halves. At the slower rates each cycle carries one nibble, repeated on both edges, so a byte takes two cycles. Double-data-rate behaviour uses one register set on each clock edge, and a clock-level multiplexer merges them.

Top module: `ddr_mac_phy_bridge`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero: `tx_nib` and `tx_ctl` in both clock halves, and `rx_byte`, `rx_dv` and `rx_err`.
- R2: With `speed[1]` = 1 (gigabit), a byte sampled at rising edge k appears on `tx_nib` as bits 3:0 while the clock is high after edge k and as bits 7:4 while the clock is low after edge k.
- R3: In every mode, `tx_ctl` carries `tx_en` while the clock is high and `tx_en ^ tx_err` while it is low, using the values sampled at the preceding rising edge.
- R4: With `speed[1]` = 0, `tx_nib` carries the same nibble in both halves of a cycle. The first cycle of an enabled run sends bits 3:0 of `tx_byte` and the next sends bits 7:4, alternating after that.
- R5: At the slower rates, a cycle with `tx_en` low restarts the nibble order, so the next enabled cycle sends bits 3:0.
- R6: At gigabit rate, the nibble sampled at rising edge k becomes bits 3:0 of `rx_byte` and the one sampled at the following falling edge becomes bits 7:4. `rx_dv` equals the control value sampled at edge k. All three outputs update at edge k+1.
- R7: `rx_err` is the exclusive-OR of the rising-half and falling-half control values. At the slower rates it is raised only together with a byte strobe, and it is set if either nibble of that byte had the error pattern.
- R8: At the slower rates, two consecutive cycles with data-valid high form one byte, with the first nibble as bits 3:0. The byte is presented with a one-cycle `rx_dv` strobe at the edge after the second nibble was sampled, and two strobes never come in adjacent cycles.
- R9: At the slower rates, if data-valid falls after only one nibble of a byte, that nibble is discarded, no strobe is given, and the next byte starts afresh.
- R10: Speed codes `00` and `01` behave identically, and codes `10` and `11` both select gigabit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| speed | input | 2 | Rate select: bit 1 set means gigabit, otherwise nibble-per-cycle |
| tx_byte | input | 8 | Transmit byte from the MAC |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_err | input | 1 | Transmit error from the MAC |
| tx_nib | output | 4 | Double-data-rate transmit nibble toward the PHY |
| tx_ctl | output | 1 | Combined enable/error line toward the PHY |
| rx_nib | input | 4 | Double-data-rate receive nibble from the PHY |
| rx_ctl | input | 1 | Combined valid/error line from the PHY |
| rx_byte | output | 8 | Rebuilt receive byte for the MAC |
| rx_dv | output | 1 | Receive data valid (a per-byte strobe at the slower rates) |
| rx_err | output | 1 | Receive error |

## Verification
The hardest case to reach is a slower-rate byte cut short after one nibble. The stimulus must drop data-valid in exactly the cycle after a single valid nibble. It then starts a fresh byte, so a leftover nibble would show up as a wrong high or low half in the next strobe. The bench drives the rising and falling halves of the PHY lines separately, once in each clock phase. This lets it set mismatched control halves and so reach the error decoding both with data-valid high and with it low.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    SPD_SLOW = 2'b00,
    SPD_MID  = 2'b01,
    SPD_GIG  = 2'b10,
    SPD_GIG2 = 2'b11
  } speed_e;

  function automatic logic is_gig(input logic [1:0] spd);
    return spd[1];
  endfunction
endpackage

// File: rtl/tx_launch.sv
module tx_launch #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gig,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              en_in,
  input  logic              err_in,
  output logic [NIB_W-1:0]  nib_out,
  output logic              ctl_out
);
  logic [NIB_W-1:0] rise_q, fall_p, fall_n, pick;
  logic             rctl_q, fctl_p, fctl_n, phase_q;

  always_comb pick = phase_q ? byte_in[BYTE_W-1:NIB_W] : byte_in[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q  <= '0;
      fall_p  <= '0;
      rctl_q  <= 1'b0;
      fctl_p  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (gig) begin
        rise_q  <= byte_in[NIB_W-1:0];
        fall_p  <= byte_in[BYTE_W-1:NIB_W];
        phase_q <= 1'b0;
      end else begin
        rise_q  <= pick;
        fall_p  <= pick;
        phase_q <= en_in ? ~phase_q : 1'b0;
      end
      rctl_q <= en_in;
      fctl_p <= en_in ^ err_in;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_n <= '0;
      fctl_n <= 1'b0;
    end else begin
      fall_n <= fall_p;
      fctl_n <= fctl_p;
    end
  end

  always_comb begin
    nib_out = clk ? rise_q : fall_n;
    ctl_out = clk ? rctl_q : fctl_n;
  end
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gig,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              ctl_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              dv_out,
  output logic              err_out
);
  logic [NIB_W-1:0] r_nib, f_nib, hold_lo;
  logic             r_ctl, f_ctl, half_q, err_acc;
  logic             cur_err;

  always_comb cur_err = r_ctl ^ f_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_nib <= '0;
      r_ctl <= 1'b0;
    end else begin
      r_nib <= nib_in;
      r_ctl <= ctl_in;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      f_nib <= '0;
      f_ctl <= 1'b0;
    end else begin
      f_nib <= nib_in;
      f_ctl <= ctl_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= '0;
      dv_out   <= 1'b0;
      err_out  <= 1'b0;
      hold_lo  <= '0;
      half_q   <= 1'b0;
      err_acc  <= 1'b0;
    end else if (gig) begin
      byte_out <= {f_nib, r_nib};
      dv_out   <= r_ctl;
      err_out  <= cur_err;
      half_q   <= 1'b0;
      err_acc  <= 1'b0;
    end else begin
      dv_out  <= 1'b0;
      err_out <= 1'b0;
      if (!r_ctl) begin
        half_q  <= 1'b0;
        err_acc <= 1'b0;
      end else if (!half_q) begin
        hold_lo <= r_nib;
        err_acc <= cur_err;
        half_q  <= 1'b1;
      end else begin
        byte_out <= {r_nib, hold_lo};
        dv_out   <= 1'b1;
        err_out  <= err_acc | cur_err;
        half_q   <= 1'b0;
        err_acc  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr_mac_phy_bridge.sv
module ddr_mac_phy_bridge #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        speed,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_en,
  input  logic              tx_err,
  output logic [NIB_W-1:0]  tx_nib,
  output logic              tx_ctl,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              rx_ctl,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_dv,
  output logic              rx_err
);
  import bridge_pkg::*;

  logic gig_mode;
  always_comb gig_mode = is_gig(speed);

  tx_launch #(.NIB_W(NIB_W)) u_tx (
    .clk(clk), .rst(rst), .gig(gig_mode),
    .byte_in(tx_byte), .en_in(tx_en), .err_in(tx_err),
    .nib_out(tx_nib), .ctl_out(tx_ctl)
  );

  rx_capture #(.NIB_W(NIB_W)) u_rx (
    .clk(clk), .rst(rst), .gig(gig_mode),
    .nib_in(rx_nib), .ctl_in(rx_ctl),
    .byte_out(rx_byte), .dv_out(rx_dv), .err_out(rx_err)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        speed,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_en,
  input logic              tx_err,
  input logic [NIB_W-1:0]  tx_nib,
  input logic              tx_ctl,
  input logic [NIB_W-1:0]  rx_nib,
  input logic              rx_ctl,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_dv,
  input logic              rx_err
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_outputs_cleared: assert property (@(posedge clk)
    rst |=> (rx_byte == '0 && !rx_dv && !rx_err));

  a_r2_gig_high_nibble: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && $past(speed[1])) |-> tx_nib == $past(tx_byte[BYTE_W-1:NIB_W]));

  a_r3_fall_ctl_xor: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1) |-> tx_ctl == ($past(tx_en) ^ $past(tx_err)));

  a_r6_gig_dv_delay: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(speed[1])) |-> rx_dv == $past(rx_ctl, 2));

  a_r7_err_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !speed[1] && $stable(speed)) |-> (!rx_err || rx_dv));

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !speed[1] && $stable(speed) && rx_dv) |=> !rx_dv);
endmodule

bind ddr_mac_phy_bridge bridge_checker #(.NIB_W(NIB_W)) u_chk (.*);

// File: tb/tb_ddr_mac_phy_bridge.sv
module tb_ddr_mac_phy_bridge;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] speed;
  logic [7:0] tx_byte;
  logic       tx_en, tx_err;
  logic [3:0] tx_nib;
  logic       tx_ctl;
  logic [3:0] rx_nib;
  logic       rx_ctl;
  logic [7:0] rx_byte;
  logic       rx_dv, rx_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] got_b;
  logic       got_dv, got_err;

  always #10 clk = ~clk;

  ddr_mac_phy_bridge dut (
    .clk(clk), .rst(rst), .speed(speed),
    .tx_byte(tx_byte), .tx_en(tx_en), .tx_err(tx_err),
    .tx_nib(tx_nib), .tx_ctl(tx_ctl),
    .rx_nib(rx_nib), .rx_ctl(rx_ctl),
    .rx_byte(rx_byte), .rx_dv(rx_dv), .rx_err(rx_err)
  );

  // {tx_byte, tx_en, tx_err, rx byte, rx dv, rx err}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {8'hA5, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    {8'h0F, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b1},
    {8'hF0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0},
    {8'h69, 1'b1, 1'b0, 8'h96, 1'b1, 1'b0},
    {8'h81, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0},
    {8'hC3, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called in the low phase; returns in the low phase of the next cycle.
  task automatic gig_vec(input logic [20:0] v, input string rq);
    logic [7:0] tb_, rb;
    logic te, terr, rdv, rer;
    {tb_, te, terr, rb, rdv, rer} = v;
    tx_byte = tb_; tx_en = te; tx_err = terr;
    rx_nib = rb[3:0]; rx_ctl = rdv;
    @(posedge clk); #5;
    chk({"R2 rise nibble ", rq}, {4'h0, tx_nib}, {4'h0, tb_[3:0]});
    chk({"R3 rise ctl ", rq}, {7'h0, tx_ctl}, {7'h0, te});
    rx_nib = rb[7:4]; rx_ctl = rdv ^ rer;
    @(negedge clk); #5;
    chk({"R2 fall nibble ", rq}, {4'h0, tx_nib}, {4'h0, tb_[7:4]});
    chk({"R3 fall ctl ", rq}, {7'h0, tx_ctl}, {7'h0, te ^ terr});
    @(posedge clk); #3;
    chk({"R6 rx byte ", rq}, rx_byte, rb);
    chk({"R6 rx dv ", rq}, {7'h0, rx_dv}, {7'h0, rdv});
    chk({"R7 rx err ", rq}, {7'h0, rx_err}, {7'h0, rer});
    @(negedge clk); #5;
  endtask

  task automatic tx_cyc(input logic [7:0] b, input logic en, input logic er,
                        input logic [3:0] exp_n, input bit chk_d, input string rq);
    tx_byte = b; tx_en = en; tx_err = er;
    @(posedge clk); #5;
    if (chk_d) chk({rq, " rise nibble"}, {4'h0, tx_nib}, {4'h0, exp_n});
    chk({"R3 rise ctl ", rq}, {7'h0, tx_ctl}, {7'h0, en});
    @(negedge clk); #5;
    if (chk_d) chk({rq, " fall nibble"}, {4'h0, tx_nib}, {4'h0, exp_n});
    chk({"R3 fall ctl ", rq}, {7'h0, tx_ctl}, {7'h0, en ^ er});
  endtask

  // Outputs sampled here reflect the nibble of the previous call.
  task automatic rx_cyc(input logic [3:0] n, input logic dv, input logic er);
    rx_nib = n; rx_ctl = dv;
    @(posedge clk); #3;
    got_b = rx_byte; got_dv = rx_dv; got_err = rx_err;
    #2;
    rx_ctl = dv ^ er;
    @(negedge clk); #5;
  endtask

  task automatic slow_suite(input logic [1:0] spd, input string tag);
    speed = spd;
    tx_cyc(8'h00, 1'b0, 1'b0, 4'h0, 0, "R4");
    // R4: nibble order and repetition on both halves
    tx_cyc(8'hA5, 1'b1, 1'b0, 4'h5, 1, {"R4 ", tag});
    tx_cyc(8'hA5, 1'b1, 1'b0, 4'hA, 1, {"R4 ", tag});
    tx_cyc(8'h3C, 1'b1, 1'b1, 4'hC, 1, {"R4 ", tag});
    tx_cyc(8'h3C, 1'b1, 1'b1, 4'h3, 1, {"R4 ", tag});
    // R5: single enabled cycle, gap, then restart at low nibble
    tx_cyc(8'hB7, 1'b1, 1'b0, 4'h7, 1, {"R5 ", tag});
    tx_cyc(8'hB7, 1'b0, 1'b0, 4'h0, 0, {"R5 ", tag});
    tx_cyc(8'h64, 1'b1, 1'b0, 4'h4, 1, {"R5 ", tag});
    tx_cyc(8'h64, 1'b1, 1'b0, 4'h6, 1, {"R5 ", tag});
    tx_cyc(8'h00, 1'b0, 1'b0, 4'h0, 0, {"R5 ", tag});
    tx_en = 1'b0;
    // R8: byte assembly, low nibble first
    rx_cyc(4'h0, 1'b0, 1'b0);
    rx_cyc(4'h5, 1'b1, 1'b0);
    rx_cyc(4'hA, 1'b1, 1'b0);
    chk({"R8 no strobe after first nibble ", tag}, {7'h0, got_dv}, 8'h0);
    rx_cyc(4'h0, 1'b0, 1'b0);
    chk({"R8 strobe ", tag}, {7'h0, got_dv}, 8'h1);
    chk({"R8 byte ", tag}, got_b, 8'hA5);
    chk({"R7 no err ", tag}, {7'h0, got_err}, 8'h0);
    rx_cyc(4'h0, 1'b0, 1'b0);
    chk({"R8 strobe one cycle ", tag}, {7'h0, got_dv}, 8'h0);
    // R9: partial byte discarded
    rx_cyc(4'h7, 1'b1, 1'b0);
    rx_cyc(4'h0, 1'b0, 1'b0);
    rx_cyc(4'h2, 1'b1, 1'b0);
    chk({"R9 no strobe on cut byte ", tag}, {7'h0, got_dv}, 8'h0);
    rx_cyc(4'h9, 1'b1, 1'b0);
    chk({"R9 still no strobe ", tag}, {7'h0, got_dv}, 8'h0);
    rx_cyc(4'h0, 1'b0, 1'b0);
    chk({"R9 fresh byte strobe ", tag}, {7'h0, got_dv}, 8'h1);
    chk({"R9 fresh byte value ", tag}, got_b, 8'h92);
    // R7: error in first nibble carried to the byte
    rx_cyc(4'h1, 1'b1, 1'b1);
    rx_cyc(4'h8, 1'b1, 1'b0);
    rx_cyc(4'h0, 1'b0, 1'b1);
    chk({"R7 err byte ", tag}, got_b, 8'h81);
    chk({"R7 err flagged ", tag}, {7'h0, got_err}, 8'h1);
    rx_cyc(4'h0, 1'b0, 1'b0);
    chk({"R7 carrier err ignored ", tag}, {6'h0, got_dv, got_err}, 8'h0);
  endtask

  initial begin
    rst = 1'b1; speed = 2'b10;
    tx_byte = 8'hFF; tx_en = 1'b1; tx_err = 1'b1;
    rx_nib = 4'hF; rx_ctl = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 tx nibble high phase", {4'h0, tx_nib}, 8'h0);
    chk("R1 tx ctl high phase", {7'h0, tx_ctl}, 8'h0);
    chk("R1 rx byte", rx_byte, 8'h0);
    chk("R1 rx flags", {6'h0, rx_dv, rx_err}, 8'h0);
    @(negedge clk); #5;
    chk("R1 tx nibble low phase", {4'h0, tx_nib}, 8'h0);
    chk("R1 tx ctl low phase", {7'h0, tx_ctl}, 8'h0);
    rst = 1'b0;
    tx_byte = 8'h00; tx_en = 1'b0; tx_err = 1'b0;
    rx_nib = 4'h0; rx_ctl = 1'b0;
    for (int i = 0; i < NV; i++) gig_vec(VEC[i], "table");
    // R10: alternate gigabit code
    speed = 2'b11;
    gig_vec({8'h5E, 1'b1, 1'b0, 8'hE5, 1'b1, 1'b0}, "R10 code 11");
    slow_suite(2'b00, "R10 slow");
    slow_suite(2'b01, "R10 mid");
    speed = 2'b10;
    gig_vec({8'h2B, 1'b1, 1'b0, 8'hB2, 1'b1, 1'b0}, "after slow");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule